// File: doc/BRIEF.md
# Dual Snapshot-Read Free-Running Counter

This block holds two independent 52-bit up-counters that advance together on a shared tick enable. An internal fractional generator makes that tick. On average it fires once every 2.5 input clocks, so a 40 MHz clock yields 16 MHz of counting. Each counter has its own run enable. It also has two stall-enable bits, one per core; while an enabled core's stall input is high, that counter pauses.

Software writes a new count in two halves, low and high, into a staging register. A separate commit strobe then copies the staged value into the live counter. Reading is a two-step handshake. An update request copies the live count into a snapshot register and clears the valid flag. The valid flag rises one cycle after the copy, and software polls it before reading the two snapshot halves.

Top module: `sct_top`

## Requirements
- R1: Each counter is 52 bits wide and wraps from 52'hF_FFFF_FFFF_FFFF to zero on its next advance.
- R2: Clock edges are numbered 1, 2, 3, ... after the edge on which reset was last sampled high. `tick_o` is high in the cycle after edge n exactly when n mod 5 is 1 or 4. This gives gaps that alternate between 3 and 2 clocks, an average of one tick every 2.5 clocks. It is never high in two consecutive cycles.
- R3: A counter advances by one on an edge only if three conditions hold at that edge: the tick is high, its run enable is set, and it is not stalled. With its run enable clear it holds its value.
- R4: A counter is stalled when `core_stall[0]` is high and its core-0 stall enable is set, or when `core_stall[1]` is high and its core-1 stall enable is set. A stall input whose enable is clear has no effect.
- R5: A write strobe on the low half stores `wdata[31:0]` into staged bits 31:0. A write strobe on the high half stores `wdata[19:0]` into staged bits 51:32. A commit strobe copies the staged value, as it stood before that edge, into the counter. Counting then continues upward from that value.
- R6: When a commit and a counting advance fall on the same edge, the counter takes the staged value and does not increment.
- R7: An update request captures the counter value present at the request edge into `snap_hi`/`snap_lo`. The valid flag is low in the cycle after the request and high from the cycle after that. It stays high until the next request.
- R8: After reset both counters, both snapshots and both valid flags are zero, and `tick_o` is low.
- R9: The two units are independent. Configuration, strobes and requests addressed to one unit leave the other unit's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_stall | input | 2 | Stall inputs from core 0 (bit 0) and core 1 (bit 1) |
| run_en | input | NUM_UNITS | Per-unit run enable |
| stall_en_c0 | input | NUM_UNITS | Per-unit enable for the core-0 stall input |
| stall_en_c1 | input | NUM_UNITS | Per-unit enable for the core-1 stall input |
| wdata | input | 32 | Data for the staging writes |
| ld_lo_wr | input | NUM_UNITS | Per-unit strobe that writes the low half of the staged value |
| ld_hi_wr | input | NUM_UNITS | Per-unit strobe that writes the high half of the staged value |
| ld_commit | input | NUM_UNITS | Per-unit strobe that copies the staged value into the counter |
| upd_req | input | NUM_UNITS | Per-unit snapshot request |
| snap_valid | output | NUM_UNITS | Per-unit flag that the snapshot is ready |
| snap_hi | output | NUM_UNITS*(CNT_W-32) | Snapshot bits 51:32, unit 0 in the low slice |
| snap_lo | output | NUM_UNITS*32 | Snapshot bits 31:0, unit 0 in the low slice |
| tick_o | output | 1 | Shared counting tick enable |

## Verification
On a single edge, a load commit can coincide with a counting tick. The bench provokes this by holding the commit strobe high with the unit running across several ticks. It then takes a snapshot and expects the staged value exactly, with no increment. A second overlap pairs a snapshot request with a tick: the expected snapshot is the count before that edge, not the incremented one. In both cases the bench's reference model supplies the expected value and the scoreboard compares it.

// File: rtl/sct_pkg.sv
package sct_pkg;

    localparam int SCT_CNT_W  = 52;
    localparam int SCT_UNITS  = 2;
    localparam int SCT_LO_W   = 32;
    localparam int SCT_GAP_A  = 2;
    localparam int SCT_GAP_B  = 3;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } tick_phase_e;

    typedef struct packed {
        logic       run;
        logic [1:0] stall_en;
    } unit_cfg_t;

    function automatic logic unit_blocked(unit_cfg_t cfg, logic [1:0] core_stall);
        return |(cfg.stall_en & core_stall);
    endfunction

    function automatic logic unit_advance(unit_cfg_t cfg, logic [1:0] core_stall, logic tick);
        return tick && cfg.run && !unit_blocked(cfg, core_stall);
    endfunction

endpackage

// File: rtl/sct_tick_gen.sv
module sct_tick_gen #(
    parameter int GAP_A = sct_pkg::SCT_GAP_A,
    parameter int GAP_B = sct_pkg::SCT_GAP_B
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import sct_pkg::*;

    localparam int MAX_GAP = (GAP_A > GAP_B) ? GAP_A : GAP_B;
    localparam int GW      = $clog2(MAX_GAP + 1);
    localparam logic [GW-1:0] LIM_A = GW'(GAP_A - 1);
    localparam logic [GW-1:0] LIM_B = GW'(GAP_B - 1);

    logic [GW-1:0] gap_cnt;
    tick_phase_e   phase;
    logic [GW-1:0] limit;

    always_comb begin
        limit = (phase == PH_FIRST) ? LIM_A : LIM_B;
        tick  = (gap_cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            phase   <= PH_FIRST;
        end else if (tick) begin
            gap_cnt <= '0;
            phase   <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sct_counter_unit.sv
module sct_counter_unit #(
    parameter int CNT_W = sct_pkg::SCT_CNT_W,
    parameter int LO_W  = sct_pkg::SCT_LO_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  sct_pkg::unit_cfg_t    cfg,
    input  logic [1:0]            core_stall,
    input  logic [LO_W-1:0]       wdata,
    input  logic                  lo_wr,
    input  logic                  hi_wr,
    input  logic                  commit,
    output logic [CNT_W-1:0]      cnt_o,
    output logic [CNT_W-1:0]      staged_o
);
    import sct_pkg::*;

    localparam int HI_W = CNT_W - LO_W;

    logic [LO_W-1:0]  stage_lo;
    logic [HI_W-1:0]  stage_hi;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] staged;
    logic             adv;

    assign staged   = {stage_hi, stage_lo};
    assign adv      = unit_advance(cfg, core_stall, tick);
    assign cnt_o    = cnt_q;
    assign staged_o = staged;

    // staging halves
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            stage_hi <= '0;
        end else begin
            if (lo_wr) stage_lo <= wdata;
            if (hi_wr) stage_hi <= wdata[HI_W-1:0];
        end
    end

    // live counter: commit has priority over an advance
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (commit) begin
            cnt_q <= staged;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sct_snapshot.sv
module sct_snapshot #(
    parameter int CNT_W = sct_pkg::SCT_CNT_W,
    parameter int LO_W  = sct_pkg::SCT_LO_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req,
    input  logic [CNT_W-1:0]        live,
    output logic                    valid,
    output logic [CNT_W-LO_W-1:0]   hi,
    output logic [LO_W-1:0]         lo
);
    logic [CNT_W-1:0] snap_q;
    logic             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            pend_q <= 1'b0;
            valid  <= 1'b0;
        end else if (req) begin
            snap_q <= live;
            pend_q <= 1'b1;
            valid  <= 1'b0;
        end else if (pend_q) begin
            pend_q <= 1'b0;
            valid  <= 1'b1;
        end
    end

    assign hi = snap_q[CNT_W-1:LO_W];
    assign lo = snap_q[LO_W-1:0];

endmodule

// File: rtl/sct_top.sv
module sct_top #(
    parameter int NUM_UNITS = sct_pkg::SCT_UNITS,
    parameter int CNT_W     = sct_pkg::SCT_CNT_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        core_stall,
    input  logic [NUM_UNITS-1:0]              run_en,
    input  logic [NUM_UNITS-1:0]              stall_en_c0,
    input  logic [NUM_UNITS-1:0]              stall_en_c1,
    input  logic [31:0]                       wdata,
    input  logic [NUM_UNITS-1:0]              ld_lo_wr,
    input  logic [NUM_UNITS-1:0]              ld_hi_wr,
    input  logic [NUM_UNITS-1:0]              ld_commit,
    input  logic [NUM_UNITS-1:0]              upd_req,
    output logic [NUM_UNITS-1:0]              snap_valid,
    output logic [NUM_UNITS*(CNT_W-32)-1:0]   snap_hi,
    output logic [NUM_UNITS*32-1:0]           snap_lo,
    output logic                              tick_o
);
    import sct_pkg::*;

    localparam int LO_W = SCT_LO_W;
    localparam int HI_W = CNT_W - LO_W;

    logic                         tick;
    logic [NUM_UNITS*CNT_W-1:0]   cnt_flat;
    logic [NUM_UNITS*CNT_W-1:0]   staged_flat;

    sct_tick_gen #(
        .GAP_A (SCT_GAP_A),
        .GAP_B (SCT_GAP_B)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign tick_o = tick;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_cfg_t cfg;
        assign cfg.run      = run_en[u];
        assign cfg.stall_en = {stall_en_c1[u], stall_en_c0[u]};

        sct_counter_unit #(
            .CNT_W (CNT_W),
            .LO_W  (LO_W)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .cfg        (cfg),
            .core_stall (core_stall),
            .wdata      (wdata),
            .lo_wr      (ld_lo_wr[u]),
            .hi_wr      (ld_hi_wr[u]),
            .commit     (ld_commit[u]),
            .cnt_o      (cnt_flat[u*CNT_W +: CNT_W]),
            .staged_o   (staged_flat[u*CNT_W +: CNT_W])
        );

        sct_snapshot #(
            .CNT_W (CNT_W),
            .LO_W  (LO_W)
        ) u_snap (
            .clk   (clk),
            .rst   (rst),
            .req   (upd_req[u]),
            .live  (cnt_flat[u*CNT_W +: CNT_W]),
            .valid (snap_valid[u]),
            .hi    (snap_hi[u*HI_W +: HI_W]),
            .lo    (snap_lo[u*LO_W +: LO_W])
        );
    end

endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
    parameter int NUM_UNITS = 2,
    parameter int CNT_W     = 52
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic [1:0]                    core_stall,
    input  logic [NUM_UNITS-1:0]          run_en,
    input  logic [NUM_UNITS-1:0]          stall_en_c0,
    input  logic [NUM_UNITS-1:0]          stall_en_c1,
    input  logic [NUM_UNITS-1:0]          commit,
    input  logic [NUM_UNITS-1:0]          upd_req,
    input  logic [NUM_UNITS-1:0]          valid,
    input  logic [NUM_UNITS*CNT_W-1:0]    cnt_flat,
    input  logic [NUM_UNITS*CNT_W-1:0]    staged_flat
);
    logic [NUM_UNITS-1:0] req_d;

    always_ff @(posedge clk) begin
        if (rst) req_d <= '0;
        else     req_d <= upd_req;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        logic blocked;
        assign blocked = (stall_en_c0[u] & core_stall[0]) | (stall_en_c1[u] & core_stall[1]);

        AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
            upd_req[u] |=> !valid[u]); // R7

        AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
            (req_d[u] && !upd_req[u]) |=> valid[u]); // R7

        AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
            commit[u] |=> cnt_flat[u*CNT_W +: CNT_W] == $past(staged_flat[u*CNT_W +: CNT_W])); // R6

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!commit[u] && (!run_en[u] || blocked || !tick)) |=> $stable(cnt_flat[u*CNT_W +: CNT_W])); // R4

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            (!commit[u] && run_en[u] && !blocked && tick)
            |=> cnt_flat[u*CNT_W +: CNT_W] == $past(cnt_flat[u*CNT_W +: CNT_W]) + 1'b1); // R3
    end

endmodule

bind sct_top sct_checker #(
    .NUM_UNITS (NUM_UNITS),
    .CNT_W     (CNT_W)
) u_sct_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_o),
    .core_stall  (core_stall),
    .run_en      (run_en),
    .stall_en_c0 (stall_en_c0),
    .stall_en_c1 (stall_en_c1),
    .commit      (ld_commit),
    .upd_req     (upd_req),
    .valid       (snap_valid),
    .cnt_flat    (cnt_flat),
    .staged_flat (staged_flat)
);

// File: tb/tb_sct_top.sv
module tb_sct_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 52;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  core_stall = '0;
    logic [1:0]  run_en = '0, stall_en_c0 = '0, stall_en_c1 = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  ld_lo_wr = '0, ld_hi_wr = '0, ld_commit = '0, upd_req = '0;
    logic [1:0]  snap_valid;
    logic [39:0] snap_hi;
    logic [63:0] snap_lo;
    logic        tick_o;

    int total = 0;
    int bad = 0;
    string req_tag = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    sct_top dut (
        .clk(clk), .rst(rst), .core_stall(core_stall), .run_en(run_en),
        .stall_en_c0(stall_en_c0), .stall_en_c1(stall_en_c1), .wdata(wdata),
        .ld_lo_wr(ld_lo_wr), .ld_hi_wr(ld_hi_wr), .ld_commit(ld_commit),
        .upd_req(upd_req), .snap_valid(snap_valid), .snap_hi(snap_hi),
        .snap_lo(snap_lo), .tick_o(tick_o)
    );

    // reference model, built from the requirements
    logic [CW-1:0] m_cnt [2];
    logic [CW-1:0] m_stg [2];
    logic [CW-1:0] q0 [$];
    logic [CW-1:0] q1 [$];
    int  edge_n = 0;
    bit  m_tick = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int u = 0; u < 2; u++) begin m_cnt[u] = '0; m_stg[u] = '0; end
            edge_n = 0;
            m_tick = 0;
        end else begin
            for (int u = 0; u < 2; u++) begin
                bit stalled;
                // R4 stall gate, R5 staging, R6 commit priority
                stalled = (stall_en_c0[u] && core_stall[0]) || (stall_en_c1[u] && core_stall[1]);
                if (upd_req[u]) begin
                    if (u == 0) q0.push_back(m_cnt[u]); else q1.push_back(m_cnt[u]);
                end
                if (ld_commit[u])                          m_cnt[u] = m_stg[u];
                else if (m_tick && run_en[u] && !stalled) m_cnt[u] = m_cnt[u] + 1'b1;
                if (ld_lo_wr[u]) m_stg[u][31:0]  = wdata;
                if (ld_hi_wr[u]) m_stg[u][51:32] = wdata[19:0];
            end
            edge_n++;
            m_tick = (edge_n % 5 == 1) || (edge_n % 5 == 4); // R2
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: tick comparison and snapshot scoreboard
    logic [1:0] valid_prev = '0;
    always @(negedge clk) begin
        if (!rst) begin
            check(tick_o == m_tick, "R2", {63'b0, tick_o}, {63'b0, m_tick});
            for (int u = 0; u < 2; u++) begin
                if (snap_valid[u] && !valid_prev[u]) begin
                    logic [CW-1:0] got, exp;
                    got = {snap_hi[u*20 +: 20], snap_lo[u*32 +: 32]};
                    if ((u == 0 ? q0.size() : q1.size()) == 0) begin
                        check(1'b0, "R7", {12'b0, got}, 64'hDEAD);
                    end else begin
                        exp = (u == 0) ? q0.pop_front() : q1.pop_front();
                        check(got == exp, req_tag, {12'b0, got}, {12'b0, exp});
                    end
                end
            end
        end
        valid_prev = snap_valid;
    end

    task automatic snap(int u);
        @(negedge clk); upd_req[u] = 1'b1;
        @(negedge clk); upd_req[u] = 1'b0;
        check(snap_valid[u] == 1'b0, "R7", {63'b0, snap_valid[u]}, 64'd0);
        @(negedge clk);
        check(snap_valid[u] == 1'b1, "R7", {63'b0, snap_valid[u]}, 64'd1);
    endtask

    task automatic load(int u, logic [CW-1:0] v);
        @(negedge clk); wdata = v[31:0]; ld_lo_wr[u] = 1'b1;
        @(negedge clk); ld_lo_wr[u] = 1'b0; wdata = {12'b0, v[51:32]}; ld_hi_wr[u] = 1'b1;
        @(negedge clk); ld_hi_wr[u] = 1'b0; ld_commit[u] = 1'b1;
        @(negedge clk); ld_commit[u] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R8 reset state
        check(snap_valid == 2'b00, "R8", {62'b0, snap_valid}, 64'd0);
        check(snap_hi == '0 && snap_lo == '0, "R8", snap_lo, 64'd0);
        req_tag = "R8"; snap(0);

        // R3 / R9: unit 0 runs, unit 1 held
        run_en = 2'b01; idle(23);
        req_tag = "R3"; snap(0);
        req_tag = "R9"; snap(1);

        // R5: staged load into unit 1 while running, counting resumes from it
        run_en = 2'b11;
        load(1, 52'h0_0123_89AB_CDEF);
        req_tag = "R5"; snap(1); idle(7); snap(1);

        // R4: enabled stall freezes unit 0, disabled stall ignored by unit 1
        stall_en_c0 = 2'b01; stall_en_c1 = 2'b00; core_stall = 2'b11;
        idle(14);
        req_tag = "R4"; snap(0); idle(5); snap(0); snap(1);
        core_stall = 2'b00; idle(6); snap(0);
        stall_en_c1 = 2'b01; core_stall = 2'b10; idle(9); snap(0);
        core_stall = 2'b00; stall_en_c0 = '0; stall_en_c1 = '0;

        // R6: commit held across ticks, snapshot taken during the overlap
        load(0, 52'h0_0000_0000_0500);
        @(negedge clk); ld_commit[0] = 1'b1;
        idle(6);
        req_tag = "R6"; snap(0);
        @(negedge clk); ld_commit[0] = 1'b0;
        idle(4); snap(0);

        // R1: wrap from all ones
        load(0, {CW{1'b1}});
        idle(8);
        req_tag = "R1"; snap(0);

        // R3: hold with run cleared
        run_en = 2'b00; idle(3);
        req_tag = "R3"; snap(1); idle(10); snap(1);

        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule